// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block takes one host-level NAND operation (an opcode byte, an optional column, an optional page address, plus the geometry of the attached flash) and turns it into the register values a flash controller needs. These are a packed control word, a second-opcode word, two address words, a transfer length and a DMA control word. After it issues a command, it polls a completion flag at a fixed interval until the flag appears or a poll limit runs out. It then emits a one-cycle clear mask for the flag and reports success or error.

Program and erase operations come in two halves. The first half (SEQIN 0x80 or ERASE1 0x60) only computes and holds the control word. The matching second half (PAGEPROG 0x10 or ERASE2 0xD0) issues that held word, with its own opcode in the second-opcode word. The number of address cycles, the data direction and the completion flag to wait for all depend on the opcode and the flash geometry.

Top module: `nand_cmd_seq`

## Requirements
- R1: An issued control word always has bit 31 set, carries the effective opcode in bits 7:0, and has bit 19 equal to the chip select sampled when that word was built. A deferred word keeps the select value it had when its first half arrived.
- R2: Bit 26 is set for read-type opcodes READ0 0x00, READ1 0x01, RNDOUT 0x05, READOOB 0x50, READID 0x90 and STATUS 0x70. Bit 25 is set for SEQIN 0x80. No other opcode sets either bit.
- R3: The cycle count n is computed as follows. A column adds 2. A page address adds 2, plus 1 more when log2 of the device size exceeds log2 of the page size plus 16. When n is nonzero, bits 30:27 hold (n-1) OR 8; otherwise they are zero. With a column, addr1 = column and addr2 = page. With only a page, addr1 = page[15:0] and addr2 = page >> 16.
- R4: READID and STATUS always use exactly one address cycle and a transfer length of 4.
- R5: On 2048-byte pages, READOOB is issued as READ0 with the column advanced by 2048. Every read of a page transfers page + spare - column bytes.
- R6: SEQIN and ERASE1 issue nothing and leave the control word output unchanged. A following PAGEPROG or ERASE2 issues the held word, with second-opcode word 0x100 | opcode and transfer length op_len. A second half with nothing held raises op_err one cycle later and issues nothing.
- R7: The second-opcode word is 0x130 for READ0 on 2048-byte pages, 0x1E0 for RNDOUT, and 0 for every other single-phase command.
- R8: When the issued word has bit 26 or bit 25 set, the DMA word becomes 0xC0000000 + length, with bit 29 also set for reads. Otherwise the DMA word keeps its previous value.
- R9: Completion waits for irq_bits bit 28 when the issued word has bit 26 set, and for bit 31 otherwise. The flag is polled once every POLL_DIV cycles. On a hit, op_done pulses together with irq_clr equal to that single flag.
- R10: When MAX_POLLS polls all miss, op_err and irq_clr pulse exactly POLL_DIV*MAX_POLLS cycles after issue. The block then returns to idle with no command held.
- R11: Requests that arrive while a command is outstanding are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Request strobe, taken when idle |
| op_code | input | 8 | NAND opcode |
| col_en | input | 1 | Column present |
| col | input | COL_W | Column byte offset |
| page_en | input | 1 | Page address present |
| page | input | PAGE_W | Page address |
| op_len | input | LEN_W | Buffered byte count for a second half |
| page_big | input | 1 | 1: 2048-byte pages, 0: 512-byte pages |
| spare_bytes | input | 8 | Spare-area size |
| dev_log2 | input | 6 | log2 of device size in bytes |
| chip_sel | input | 1 | Chip select |
| irq_bits | input | 32 | Controller interrupt flags |
| ctrl_word | output | 32 | Issued control word |
| cmd2_word | output | 32 | Second-opcode word |
| addr1 | output | 32 | First address word |
| addr2 | output | 32 | Second address word |
| xfer_len | output | LEN_W | Transfer length |
| dma_word | output | 32 | DMA control word |
| issue | output | 1 | One-cycle pulse when ctrl_word is issued |
| busy | output | 1 | Waiting for completion |
| op_done | output | 1 | Completion pulse |
| op_err | output | 1 | Timeout or orphan second-half pulse |
| irq_clr | output | 32 | One-cycle flag clear mask |

## Verification
The assertions assume that a request is presented only with a legal opcode. They also assume that a read request carries a column, so the length never wraps, and that the geometry inputs stay fixed while a command is outstanding. The directed tasks change page_big, spare_bytes and dev_log2 only between operations. They send reads only with col_en set. The flag-mismatch scenarios, such as a DMA read answered on bit 31 alone, rely on timeouts, which stay short because the bench uses small poll parameters.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int COL_W     = 16,
  parameter int PAGE_W    = 24,
  parameter int LEN_W     = 16,
  parameter int POLL_DIV  = 100,
  parameter int MAX_POLLS = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  input  logic              col_en,
  input  logic [COL_W-1:0]  col,
  input  logic              page_en,
  input  logic [PAGE_W-1:0] page,
  input  logic [LEN_W-1:0]  op_len,
  input  logic              page_big,
  input  logic [7:0]        spare_bytes,
  input  logic [5:0]        dev_log2,
  input  logic              chip_sel,
  input  logic [31:0]       irq_bits,
  output logic [31:0]       ctrl_word,
  output logic [31:0]       cmd2_word,
  output logic [31:0]       addr1,
  output logic [31:0]       addr2,
  output logic [LEN_W-1:0]  xfer_len,
  output logic [31:0]       dma_word,
  output logic              issue,
  output logic              busy,
  output logic              op_done,
  output logic              op_err,
  output logic [31:0]       irq_clr
);
  localparam int TW = $clog2(POLL_DIV + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [7:0] OP_READ0 = 8'h00, OP_READ1 = 8'h01, OP_RNDOUT = 8'h05,
                         OP_OOB = 8'h50, OP_ID = 8'h90, OP_STAT = 8'h70,
                         OP_SEQIN = 8'h80, OP_PROG = 8'h10, OP_ER1 = 8'h60,
                         OP_ER2 = 8'hD0, OP_RSTART = 8'h30, OP_ROSTART = 8'hE0;

  logic [LEN_W-1:0] pg_bytes, eff_col, new_len, iss_len;
  logic [7:0]  eff_op;
  logic        oob_conv, extra, is_id, is_rd, is_wr, first_half, second_half;
  logic [2:0]  n_raw, n_cyc;
  logic [3:0]  cyc_field;
  logic [31:0] new_word, new_cmd2, iss_word, held_word;
  logic        held_ok, accept, do_issue;
  logic [31:0] flag_mask;
  logic [TW-1:0] tick;
  logic [PW-1:0] polls;

  assign pg_bytes    = page_big ? LEN_W'(2048) : LEN_W'(512);
  assign oob_conv    = page_big && op_code == OP_OOB;
  assign eff_op      = oob_conv ? OP_READ0 : op_code;
  assign eff_col     = LEN_W'(col) + (oob_conv ? pg_bytes : '0);
  assign extra       = dev_log2 > (page_big ? 6'd27 : 6'd25);
  assign is_id       = eff_op == OP_ID || eff_op == OP_STAT;
  assign is_rd       = eff_op == OP_READ0 || eff_op == OP_READ1 ||
                       eff_op == OP_OOB || eff_op == OP_RNDOUT;
  assign is_wr       = eff_op == OP_SEQIN;
  assign first_half  = op_code == OP_SEQIN || op_code == OP_ER1;
  assign second_half = op_code == OP_PROG || op_code == OP_ER2;

  assign n_raw     = (col_en ? 3'd2 : 3'd0) + (page_en ? 3'd2 + {2'b0, extra} : 3'd0);
  assign n_cyc     = is_id ? 3'd1 : n_raw;
  assign cyc_field = (n_cyc != 0) ? ({1'b0, n_cyc - 3'd1} | 4'b1000) : 4'b0000;
  assign new_len   = is_id ? LEN_W'(4) :
                     is_rd ? pg_bytes + LEN_W'(spare_bytes) - eff_col : '0;
  assign new_word  = {1'b1, cyc_field, is_rd | is_id, is_wr, 5'b0, chip_sel, 11'b0, eff_op};
  assign new_cmd2  = (eff_op == OP_RNDOUT) ? {24'h0, 8'h01, OP_ROSTART} & 32'h1FF :
                     (eff_op == OP_READ0 && page_big) ? 32'h100 | {24'h0, OP_RSTART} : 32'h0;

  assign accept   = op_valid && !busy;
  assign do_issue = accept && (second_half ? held_ok : !first_half);
  assign iss_word = second_half ? held_word : new_word;
  assign iss_len  = second_half ? op_len : new_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word <= '0; cmd2_word <= '0; addr1 <= '0; addr2 <= '0;
      xfer_len <= '0; dma_word <= '0; issue <= 1'b0; busy <= 1'b0;
      op_done <= 1'b0; op_err <= 1'b0; irq_clr <= '0;
      held_word <= '0; held_ok <= 1'b0; flag_mask <= '0;
      tick <= '0; polls <= '0;
    end else begin
      issue   <= 1'b0;
      op_done <= 1'b0;
      op_err  <= 1'b0;
      irq_clr <= '0;
      if (accept) begin
        if (second_half) begin
          if (held_ok) cmd2_word <= 32'h100 | {24'h0, op_code};
          else op_err <= 1'b1;
        end else begin
          cmd2_word <= new_cmd2;
          if (col_en) begin
            addr1 <= 32'(eff_col);
            if (page_en) addr2 <= 32'(page);
          end else if (page_en) begin
            addr1 <= {16'h0, page[15:0]};
            addr2 <= 32'(page >> 16);
          end
          if (first_half) begin
            held_word <= new_word;
            held_ok   <= 1'b1;
          end
        end
      end
      if (do_issue) begin
        ctrl_word <= iss_word;
        xfer_len  <= iss_len;
        if (iss_word[26] || iss_word[25])
          dma_word <= 32'hC000_0000 + 32'(iss_len) + (iss_word[26] ? 32'h2000_0000 : 32'h0);
        flag_mask <= iss_word[26] ? 32'h1000_0000 : 32'h8000_0000;
        if (second_half) held_ok <= 1'b0;
        issue <= 1'b1;
        busy  <= 1'b1;
        tick  <= '0;
        polls <= '0;
      end else if (busy) begin
        if (tick == TW'(POLL_DIV - 1)) begin
          tick <= '0;
          if ((irq_bits & flag_mask) != 0) begin
            busy    <= 1'b0;
            op_done <= 1'b1;
            irq_clr <= flag_mask;
          end else if (polls == PW'(MAX_POLLS - 1)) begin
            busy    <= 1'b0;
            op_err  <= 1'b1;
            irq_clr <= flag_mask;
            held_ok <= 1'b0;
          end else begin
            polls <= polls + 1'b1;
          end
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      ctrl_word,
  input logic [31:0]      dma_word,
  input logic [LEN_W-1:0] xfer_len,
  input logic             issue,
  input logic             busy,
  input logic             op_done,
  input logic             op_err,
  input logic [31:0]      irq_clr
);
  p_valid_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ctrl_word[31]);
  p_dir_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !(ctrl_word[26] && ctrl_word[25]));
  p_cyc_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && ctrl_word[30:27] != 4'd0) |-> ctrl_word[30]);
  p_dma_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && ctrl_word[26]) |-> (dma_word[31:29] == 3'b111 && dma_word[15:0] == 16'(xfer_len)));
  p_clear_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> ($countones(irq_clr) == 1 && (irq_clr[31] || irq_clr[28])));
  p_end_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_done && op_err));
  p_issue_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> busy);
  p_hold_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctrl_word));
endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .dma_word(dma_word),
  .xfer_len(xfer_len), .issue(issue), .busy(busy), .op_done(op_done),
  .op_err(op_err), .irq_clr(irq_clr));

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb_top;
  localparam int PD = 3, MP = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, col_en = 1'b0, page_en = 1'b0, page_big = 1'b0, chip_sel = 1'b0;
  logic [7:0] op_code = '0, spare_bytes = 8'd16;
  logic [15:0] col = '0, op_len = '0;
  logic [23:0] page = '0;
  logic [5:0] dev_log2 = 6'd25;
  logic [31:0] irq_bits = '0;
  logic [31:0] ctrl_word, cmd2_word, addr1, addr2, dma_word, irq_clr;
  logic [15:0] xfer_len;
  logic issue, busy, op_done, op_err;
  int checks = 0, errors = 0;
  bit seen_issue, got_done, got_err;
  logic [31:0] got_clr;
  int wait_cyc;

  always #5 clk = ~clk;

  nand_cmd_seq #(.POLL_DIV(PD), .MAX_POLLS(MP)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .col_en(col_en),
    .col(col), .page_en(page_en), .page(page), .op_len(op_len), .page_big(page_big),
    .spare_bytes(spare_bytes), .dev_log2(dev_log2), .chip_sel(chip_sel), .irq_bits(irq_bits),
    .ctrl_word(ctrl_word), .cmd2_word(cmd2_word), .addr1(addr1), .addr2(addr2),
    .xfer_len(xfer_len), .dma_word(dma_word), .issue(issue), .busy(busy),
    .op_done(op_done), .op_err(op_err), .irq_clr(irq_clr));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] op, logic ce, logic [15:0] c, logic pe, logic [23:0] p,
                      logic [15:0] ln);
    @(negedge clk);
    op_code = op; col_en = ce; col = c; page_en = pe; page = p; op_len = ln; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    seen_issue = issue;
  endtask

  task automatic wait_end();
    got_done = 0; got_err = 0; got_clr = '0; wait_cyc = 0;
    for (int i = 0; i < 200; i++) begin
      if (op_done || op_err) begin
        got_done = op_done; got_err = op_err; got_clr = irq_clr;
        return;
      end
      @(negedge clk);
      wait_cyc++;
    end
  endtask

  task automatic t_reset();
    check("R1 reset ctrl", ctrl_word, 32'h0);
    check("R9 reset busy", {31'b0, busy}, 32'h0);
  endtask

  task automatic t_readid();
    chip_sel = 1; irq_bits = 32'h1000_0000;
    send(8'h90, 1, 16'h0, 0, 24'h0, 16'h0);
    check("R1 R4 readid word", ctrl_word, 32'hC408_0090);
    check("R4 readid len", {16'h0, xfer_len}, 32'h4);
    check("R8 readid dma", dma_word, 32'hE000_0004);
    wait_end();
    check("R9 readid done", {31'b0, got_done}, 32'h1);
    check("R9 readid clr", got_clr, 32'h1000_0000);
    chip_sel = 0;
  endtask

  task automatic t_status();
    irq_bits = 32'h1000_0000;
    send(8'h70, 0, 16'h0, 0, 24'h0, 16'h0);
    check("R4 status word", ctrl_word, 32'hC400_0070);
    wait_end();
  endtask

  task automatic t_read_small();
    page_big = 0; spare_bytes = 16; dev_log2 = 25; irq_bits = 32'h1000_0000;
    send(8'h00, 1, 16'h10, 1, 24'h1234, 16'h0);
    check("R3 small read word", ctrl_word, 32'hDC00_0000);
    check("R5 small read len", {16'h0, xfer_len}, 32'h200);
    check("R7 small read cmd2", cmd2_word, 32'h0);
    check("R3 small addr1", addr1, 32'h10);
    check("R3 small addr2", addr2, 32'h1234);
    wait_end();
  endtask

  task automatic t_read_large();
    page_big = 1; spare_bytes = 64; dev_log2 = 28; irq_bits = 32'h1000_0000;
    send(8'h00, 1, 16'h0, 1, 24'h40, 16'h0);
    check("R3 extra cycle word", ctrl_word, 32'hE400_0000);
    check("R5 large len", {16'h0, xfer_len}, 32'h840);
    check("R7 readstart", cmd2_word, 32'h130);
    check("R8 large dma", dma_word, 32'hE000_0840);
    wait_end();
  endtask

  task automatic t_oob();
    page_big = 1; spare_bytes = 64; dev_log2 = 27; irq_bits = 32'h1000_0000;
    send(8'h50, 1, 16'h0, 1, 24'h7, 16'h0);
    check("R5 oob word", ctrl_word, 32'hDC00_0000);
    check("R5 oob col", addr1, 32'h800);
    check("R5 oob len", {16'h0, xfer_len}, 32'h40);
    check("R7 oob cmd2", cmd2_word, 32'h130);
    wait_end();
  endtask

  task automatic t_rndout();
    irq_bits = 32'h1000_0000;
    send(8'h05, 1, 16'h100, 0, 24'h0, 16'h0);
    check("R2 rndout word", ctrl_word, 32'hCC00_0005);
    check("R7 rndout cmd2", cmd2_word, 32'h1E0);
    check("R5 rndout len", {16'h0, xfer_len}, 32'h740);
    wait_end();
  endtask

  task automatic t_erase();
    page_big = 1; dev_log2 = 28; irq_bits = 32'h8000_0000;
    send(8'h60, 0, 16'h0, 1, 24'h12345, 16'h0);
    check("R6 erase1 no issue", {31'b0, seen_issue}, 32'h0);
    check("R6 erase1 ctrl held", ctrl_word, 32'hCC00_0005);
    check("R3 page addr1", addr1, 32'h2345);
    check("R3 page addr2", addr2, 32'h1);
    send(8'hD0, 0, 16'h0, 0, 24'h0, 16'h0);
    check("R6 erase2 word", ctrl_word, 32'hD000_0060);
    check("R6 erase2 cmd2", cmd2_word, 32'h1D0);
    check("R8 no data phase dma kept", dma_word, 32'hE000_0740);
    wait_end();
    check("R9 erase done", {31'b0, got_done}, 32'h1);
    check("R9 erase clr", got_clr, 32'h8000_0000);
  endtask

  task automatic t_program();
    page_big = 0; spare_bytes = 16; dev_log2 = 25; chip_sel = 1; irq_bits = 32'h8000_0000;
    send(8'h80, 1, 16'h0, 1, 24'h22, 16'h0);
    check("R6 seqin no issue", {31'b0, seen_issue}, 32'h0);
    chip_sel = 0;
    send(8'h10, 0, 16'h0, 0, 24'h0, 16'd528);
    check("R1 R2 program word", ctrl_word, 32'hDA08_0080);
    check("R6 program cmd2", cmd2_word, 32'h110);
    check("R6 program len", {16'h0, xfer_len}, 32'h210);
    check("R8 write dma", dma_word, 32'hC000_0210);
    wait_end();
    check("R9 program done", {31'b0, got_done}, 32'h1);
  endtask

  task automatic t_orphan();
    send(8'h10, 0, 16'h0, 0, 24'h0, 16'd4);
    check("R6 orphan no issue", {31'b0, seen_issue}, 32'h0);
    check("R6 orphan err", {31'b0, op_err}, 32'h1);
  endtask

  task automatic t_wrong_flag();
    irq_bits = 32'h8000_0000;
    send(8'h00, 1, 16'h0, 1, 24'h3, 16'h0);
    wait_end();
    check("R9 dma read ignores bit31", {31'b0, got_err}, 32'h1);
    check("R10 timeout clr", got_clr, 32'h1000_0000);
  endtask

  task automatic t_timeout();
    irq_bits = 32'h0;
    send(8'h80, 1, 16'h0, 1, 24'h5, 16'h0);
    send(8'h10, 0, 16'h0, 0, 24'h0, 16'd8);
    wait_end();
    check("R10 timeout err", {31'b0, got_err}, 32'h1);
    check("R10 timeout cycles", 32'(wait_cyc), 32'(PD * MP));
    @(negedge clk);
    check("R10 idle after timeout", {31'b0, busy}, 32'h0);
    send(8'h10, 0, 16'h0, 0, 24'h0, 16'd8);
    check("R10 latch dropped", {31'b0, seen_issue}, 32'h0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] w;
    irq_bits = 32'h0;
    send(8'h00, 1, 16'h0, 1, 24'h9, 16'h0);
    w = ctrl_word;
    @(negedge clk);
    op_code = 8'h70; col_en = 0; page_en = 0; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check("R11 busy ctrl kept", ctrl_word, w);
    wait_end();
    check("R11 original wait length", 32'(wait_cyc), 32'(PD * MP - 2));
    @(negedge clk);
    check("R11 no late issue", {31'b0, issue}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readid();
    t_status();
    t_read_small();
    t_read_large();
    t_oob();
    t_rndout();
    t_erase();
    t_program();
    t_orphan();
    t_wrong_flag();
    t_timeout();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule